// File: doc/BRIEF.md
# Dual Baud Rate Generator with Steered Divisor Writes

This block divides a system clock into a transmit baud tick and a receive baud tick. Each tick runs at the chosen oversampling multiple of the serial bit rate. A bit-centre strobe accompanies each direction. Software loads a 16-bit integer divisor and an extension byte through a small write port. The extension byte holds four settings: a fractional divisor in sixteenths of a clock, the oversampling choice, a flag that splits the generator in two, and a flag that chooses the write target.

In shared mode, one divisor set drives both directions, and the receive outputs mirror the transmit outputs. In split mode, the target flag sends each divisor write to either the transmit set or the receive set. If the generator is shared and the target flag is set, divisor writes are discarded. The shift registers, FIFOs and interrupt logic that use these ticks sit outside this block.

Top module: `dual_baud_gen`

## Requirements
- R1: After reset, both divisor sets are zero, the generator is shared, the write target is 0, and 16x oversampling is selected. No tick and no centre strobe appears until a nonzero divisor is written.
- R2: The divisor is {high byte, low byte}. The low byte is written at address 0 and the high byte at address 1. With a zero fraction, a nonzero divisor D gives exactly one tick every D clocks.
- R3: Extension bits [3:0] (address 2) hold a fraction F in sixteenths. Any 16 consecutive tick intervals then total exactly 16*D+F clocks.
- R4: Extension bits [5:4] choose the oversampling rate N: 00 gives 16, 01 gives 8, and 10 or 11 gives 4. The centre strobe fires once every N ticks, always in the same cycle as a tick.
- R5: When extension bit 6 is 0 and bit 7 is 0, divisor and extension [5:0] writes configure the shared set. While bit 6 is 0, the receive tick and centre equal the transmit tick and centre in every cycle.
- R6: When extension bit 6 is 1, bit 7 picks the target of divisor and extension [5:0] writes: 0 for transmit, 1 for receive. The two directions then run at independent rates.
- R7: When extension bit 6 is 0 and bit 7 is 1, divisor and extension [5:0] writes change neither set.
- R8: An extension write always stores bits [7:6]. The bits [5:0] of that same write are steered by the new bits [7:6].
- R9: A direction whose divisor is zero produces no tick and no centre strobe.
- R10: A new nonzero divisor does not shorten the interval in progress. It takes effect from the next counter reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 divisor low, 1 divisor high, 2 extension, 3 unused |
| wr_data | input | 8 | Write data |
| tx_tick | output | 1 | Transmit oversample tick |
| tx_center | output | 1 | Transmit bit-centre strobe |
| rx_tick | output | 1 | Receive oversample tick |
| rx_center | output | 1 | Receive bit-centre strobe |

## Verification
Several properties are checked by assertions on every cycle. A zero divisor keeps its generator silent, and a centre strobe never appears without a tick. The receive outputs mirror the transmit outputs while the generator is shared, and a discarded write leaves both divisor sets unchanged. The stored control bits always follow an extension write.

Other behaviour shows only over many cycles, so only the bench scenarios can show it. These scenarios measure exact tick intervals and the 16-period sums with a fraction. They count the ticks between centre strobes for each oversampling setting and compare the independent transmit and receive rates. They also check that a divisor written mid-period waits for the reload.

// File: rtl/dual_baud_gen.sv
module dual_baud_gen #(
  parameter int BYTE_W = 8,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              tx_tick,
  output logic              tx_center,
  output logic              rx_tick,
  output logic              rx_center
);
  localparam int DIV_W = 2 * BYTE_W;
  localparam int OSC_W = 4;

  logic              indep_q, sel_q;
  logic [BYTE_W-1:0] lo_q [2];
  logic [BYTE_W-1:0] hi_q [2];
  logic [FRAC_W-1:0] frac_q [2];
  logic [1:0]        os_q [2];
  logic [1:0]        g_tick, g_ctr, hit;

  wire ext_wr    = wr_en && (wr_addr == 2'd2);
  wire new_indep = ext_wr ? wr_data[6] : indep_q;
  wire new_sel   = ext_wr ? wr_data[7] : sel_q;

  assign hit[0] = wr_en && !new_sel;
  assign hit[1] = wr_en && new_indep && new_sel;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      indep_q <= 1'b0;
      sel_q   <= 1'b0;
    end else if (ext_wr) begin
      indep_q <= wr_data[6];
      sel_q   <= wr_data[7];
    end

  for (genvar g = 0; g < 2; g++) begin : g_gen
    logic [DIV_W-1:0]  div, cnt;
    logic [FRAC_W-1:0] acc;
    logic [FRAC_W:0]   sum;
    logic [OSC_W-1:0]  osc, last, half;
    logic              active, at_zero;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        lo_q[g]   <= '0;
        hi_q[g]   <= '0;
        frac_q[g] <= '0;
        os_q[g]   <= 2'b00;
      end else if (hit[g]) begin
        case (wr_addr)
          2'd0:    lo_q[g] <= wr_data;
          2'd1:    hi_q[g] <= wr_data;
          2'd2:    {os_q[g], frac_q[g]} <= wr_data[5:0];
          default: ;
        endcase
      end

    assign div     = {hi_q[g], lo_q[g]};
    assign active  = (div != '0);
    assign at_zero = (cnt == '0);
    assign sum     = {1'b0, acc} + {1'b0, frac_q[g]};
    assign last    = (os_q[g] == 2'b00) ? OSC_W'(15) : (os_q[g] == 2'b01) ? OSC_W'(7) : OSC_W'(3);
    assign half    = (os_q[g] == 2'b00) ? OSC_W'(8)  : (os_q[g] == 2'b01) ? OSC_W'(4) : OSC_W'(2);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt       <= '0;
        acc       <= '0;
        osc       <= '0;
        g_tick[g] <= 1'b0;
        g_ctr[g]  <= 1'b0;
      end else if (!active) begin
        cnt       <= '0;
        acc       <= '0;
        osc       <= '0;
        g_tick[g] <= 1'b0;
        g_ctr[g]  <= 1'b0;
      end else begin
        g_tick[g] <= at_zero;
        g_ctr[g]  <= at_zero && (osc == half);
        if (at_zero) begin
          cnt <= div - DIV_W'(1) + DIV_W'(sum[FRAC_W]);
          acc <= sum[FRAC_W-1:0];
          osc <= (osc >= last) ? '0 : osc + OSC_W'(1);
        end else begin
          cnt <= cnt - DIV_W'(1);
        end
      end
  end

  assign tx_tick   = g_tick[0];
  assign tx_center = g_ctr[0];
  assign rx_tick   = indep_q ? g_tick[1] : g_tick[0];
  assign rx_center = indep_q ? g_ctr[1]  : g_ctr[0];
endmodule

module dual_baud_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       indep_q,
  input logic       sel_q,
  input logic [7:0] lo0,
  input logic [7:0] hi0,
  input logic [7:0] lo1,
  input logic [7:0] hi1,
  input logic [3:0] fr0,
  input logic [3:0] fr1,
  input logic [1:0] os0,
  input logic [1:0] os1,
  input logic [1:0] g_tick,
  input logic       tx_tick,
  input logic       tx_center,
  input logic       rx_tick,
  input logic       rx_center
);
  wire discard = wr_en && ((wr_addr == 2'd2) ? (!wr_data[6] && wr_data[7]) : (!indep_q && sel_q));

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (!tx_tick && !rx_tick));

  assert_center_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_center |-> tx_tick) and (rx_center |-> rx_tick));

  assert_shared_mirror_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !indep_q |-> (rx_tick == tx_tick && rx_center == tx_center));

  assert_discard_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    discard |=> ($stable(lo0) && $stable(hi0) && $stable(lo1) && $stable(hi1) &&
                 $stable(fr0) && $stable(fr1) && $stable(os0) && $stable(os1)));

  assert_ctl_stored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd2) |=> ({sel_q, indep_q} == $past(wr_data[7:6])));

  assert_zero_div_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((lo0 == 8'd0 && hi0 == 8'd0) |=> !g_tick[0]) and ((lo1 == 8'd0 && hi1 == 8'd0) |=> !g_tick[1]));
endmodule

bind dual_baud_gen dual_baud_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .indep_q(indep_q), .sel_q(sel_q),
  .lo0(lo_q[0]), .hi0(hi_q[0]), .lo1(lo_q[1]), .hi1(hi_q[1]),
  .fr0(frac_q[0]), .fr1(frac_q[1]), .os0(os_q[0]), .os1(os_q[1]),
  .g_tick(g_tick), .tx_tick(tx_tick), .tx_center(tx_center),
  .rx_tick(rx_tick), .rx_center(rx_center)
);

// File: tb/tb_dual_baud_gen.sv
module tb_dual_baud_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       tx_tick, tx_center, rx_tick, rx_center;
  int         errors = 0;
  int         checks = 0;
  int         cycles = 0;

  dual_baud_gen dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tx_tick(tx_tick), .tx_center(tx_center), .rx_tick(rx_tick), .rx_center(rx_center)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 190000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic bit tk(input bit rx);
    return rx ? rx_tick : tx_tick;
  endfunction

  function automatic bit ct(input bit rx);
    return rx ? rx_center : tx_center;
  endfunction

  task automatic wait_tick(input bit rx);
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (tk(rx)) return;
    end
  endtask

  task automatic wait_ctr(input bit rx);
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (ct(rx)) return;
    end
  endtask

  task automatic interval(input bit rx, output int c);
    c = 0;
    do begin
      @(negedge clk);
      c++;
    end while (!tk(rx) && c < 20000);
  endtask

  task automatic meas(input bit rx, input int n, output int total);
    int c;
    wait_tick(rx);
    wait_tick(rx);
    total = 0;
    for (int i = 0; i < n; i++) begin
      interval(rx, c);
      total += c;
    end
  endtask

  task automatic ctr_span(input bit rx, output int n);
    wait_ctr(rx);
    wait_ctr(rx);
    n = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (tk(rx)) n++;
      if (ct(rx)) return;
    end
  endtask

  task automatic count_ticks(input int len, output int n);
    n = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (tx_tick || rx_tick || tx_center || rx_center) n++;
    end
  endtask

  task automatic mirror(input int len, output int bad);
    bad = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (rx_tick != tx_tick || rx_center != tx_center) bad++;
    end
  endtask

  task automatic t_reset;
    int n;
    count_ticks(100, n);
    check(n == 0, "R1 reset quiet", n, 0);
  endtask

  task automatic t_shared_default;
    int tot, bad, sp;
    wr(2'd0, 8'd5);
    meas(1'b0, 16, tot);
    check(tot == 80, "R2 divisor 5 over 16 periods", tot, 80);
    meas(1'b1, 16, tot);
    check(tot == 80, "R5 shared rx period", tot, 80);
    mirror(200, bad);
    check(bad == 0, "R5 rx mirrors tx", bad, 0);
    ctr_span(1'b0, sp);
    check(sp == 16, "R1 default 16x centre spacing", sp, 16);
  endtask

  task automatic t_fraction;
    int tot;
    wr(2'd2, 8'h03);
    meas(1'b0, 16, tot);
    check(tot == 83, "R3 fraction 3/16", tot, 83);
    wr(2'd2, 8'h0F);
    meas(1'b0, 16, tot);
    check(tot == 95, "R3 fraction 15/16", tot, 95);
  endtask

  task automatic t_oversample;
    int sp;
    wr(2'd2, 8'h10);
    ctr_span(1'b0, sp);
    check(sp == 8, "R4 select 01 gives 8", sp, 8);
    wr(2'd2, 8'h20);
    ctr_span(1'b0, sp);
    check(sp == 4, "R4 select 10 gives 4", sp, 4);
    wr(2'd2, 8'h30);
    ctr_span(1'b0, sp);
    check(sp == 4, "R4 select 11 gives 4", sp, 4);
    wr(2'd2, 8'h00);
    ctr_span(1'b0, sp);
    check(sp == 16, "R4 select 00 gives 16", sp, 16);
  endtask

  task automatic t_independent;
    int tot;
    wr(2'd2, 8'h40);
    wr(2'd0, 8'd4);
    wr(2'd1, 8'd0);
    wr(2'd2, 8'hC0);
    wr(2'd0, 8'd7);
    wr(2'd1, 8'd0);
    meas(1'b0, 16, tot);
    check(tot == 64, "R6 tx divisor 4", tot, 64);
    meas(1'b1, 16, tot);
    check(tot == 112, "R6 rx divisor 7", tot, 112);
  endtask

  task automatic t_discard;
    int tot, bad, sp;
    wr(2'd2, 8'h9A);
    wr(2'd0, 8'd2);
    wr(2'd1, 8'd1);
    meas(1'b0, 16, tot);
    check(tot == 64, "R7 divisor write discarded", tot, 64);
    ctr_span(1'b0, sp);
    check(sp == 16, "R7 extension bits discarded", sp, 16);
    mirror(200, bad);
    check(bad == 0, "R8 shared stored by discard write", bad, 0);
  endtask

  task automatic t_zero;
    int n;
    wr(2'd2, 8'h00);
    wr(2'd0, 8'd0);
    count_ticks(300, n);
    check(n == 0, "R9 zero divisor silent", n, 0);
  endtask

  task automatic t_high_byte;
    int tot, sp;
    wr(2'd2, 8'h20);
    wr(2'd1, 8'd1);
    meas(1'b0, 16, tot);
    check(tot == 4096, "R2 high byte divisor 256", tot, 4096);
    ctr_span(1'b0, sp);
    check(sp == 4, "R4 4x at divisor 256", sp, 4);
  endtask

  task automatic t_reload;
    int c, c2;
    wr(2'd2, 8'h00);
    wr(2'd1, 8'd0);
    wr(2'd0, 8'd20);
    wait_tick(1'b0);
    wait_tick(1'b0);
    c = 0;
    do begin
      @(negedge clk);
      c++;
      if (c == 3) begin
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'd10;
      end else if (c == 4) begin
        wr_en = 1'b0;
      end
    end while (!tx_tick && c < 20000);
    check(c == 20, "R10 current period kept", c, 20);
    interval(1'b0, c2);
    check(c2 == 10, "R10 new divisor after reload", c2, 10);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_shared_default();
    t_fraction();
    t_oversample();
    t_independent();
    t_discard();
    t_zero();
    t_high_byte();
    t_reload();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule